// File: doc/BRIEF.md
# NAND Hamming ECC Generator and Corrector

This block protects one 512-byte chunk of NAND page data with a 24-bit Hamming code. Data bytes stream in after a clear strobe. The block keeps twelve parity pairs. Each pair has a "true" half and a "complement" half. Three pairs index the bit position inside a byte, and nine pairs index the byte address. When the 512th byte has been accepted, the computed code appears as three bytes, together with a one-cycle done pulse. The code is not inverted, so a chunk of erased (all 0xFF) bytes yields a code of zero.

On a read, the controller places the 3-byte code fetched from the spare area on the stored-code input and raises the compare strobe. The block unpacks both codes into a 32-bit form and takes their XOR as the syndrome. It classifies the result from the number of set syndrome bits, and for a single data-bit error it reports the byte and bit to flip. A stored code that matches the erased-page pattern, paired with a computed code of zero, is accepted as clean. Applying the correction to memory is left to the surrounding logic.

Top module: `nand_ecc_engine`

## Requirements
- R1: After reset, and in the cycle after a clear strobe, code_done, result_valid, status, err_byte and err_bit are all zero. A clear also restarts the accumulation of a new chunk.
- R2: In the 32-bit unpacked code form, bit k+16 (for k from 0 to 11) is the XOR of all data bits whose 12-bit position (byte_index*8 + bit_index) has bit k equal to 1. Bit k is the XOR of those whose position has bit k equal to 0. The other bits are zero. code_out[7:0] carries unpacked bits 7:0. code_out[15:8] carries bits 23:16. code_out[23:20] carries bits 27:24, and code_out[19:16] carries bits 11:8.
- R3: code_done is high for exactly one cycle, in the cycle after the 512th byte is accepted. Bytes offered after the 512th, until the next clear, do not change code_out and raise no code_done.
- R4: A chunk of 512 bytes of 0xFF produces code_out equal to zero.
- R5: The stored code is unpacked with the same layout as R2, and the syndrome is the XOR of the two unpacked codes. A zero syndrome gives status 0 (clean).
- R6: A syndrome with exactly 12 bits set gives status 1 (correctable). err_byte equals syndrome bits 27:19, and err_bit equals syndrome bits 18:16.
- R7: A syndrome with exactly one bit set gives status 2 (stored code corrupt, data good).
- R8: An unpacked stored code of 0x0FFF0FFF with a computed code of zero gives status 0.
- R9: Any other nonzero syndrome gives status 3 (uncorrectable).
- R10: result_valid and the status fields update on the second clock edge after a sampled compare strobe. They hold until the next clear. err_byte and err_bit are zero unless status is 1. A compare strobe given before the chunk is complete is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clear strobe; starts a new chunk |
| in_valid | input | 1 | Data byte valid |
| in_byte | input | 8 | Data byte |
| cmp_req | input | 1 | Compare strobe |
| stored_code | input | 24 | Code from spare area, byte 0 in [7:0] |
| code_out | output | 24 | Computed code, byte 0 in [7:0] |
| code_done | output | 1 | One-cycle pulse when code_out becomes valid |
| result_valid | output | 1 | Classification available |
| status | output | 2 | 0 clean, 1 correctable, 2 code corrupt, 3 uncorrectable |
| err_byte | output | 9 | Byte index to correct |
| err_bit | output | 3 | Bit index to correct |

## Verification
Reaching the correctable and erased branches from the ports is the hard part. A correctable result needs a stored code that is exactly right for data which then differs in one chosen bit. The erased branch needs the precise all-ones spare pattern together with a zero computed code. The bench therefore computes the code of a known chunk in its own model, feeds the same chunk with one bit inverted at the chosen corner positions (first byte and bit, last byte and bit, and interior positions), and compares against the clean code. It also feeds an all-0xFF chunk against both the exact erased pattern and a pattern one bit away from it.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int CHUNK_BYTES = 512;
  localparam int ADDR_W      = $clog2(CHUNK_BYTES);
  localparam int BIT_W       = 3;
  localparam int PAIRS       = BIT_W + ADDR_W;
  localparam int WORD_W      = 32;
  localparam int CODE_W      = 24;
  localparam int HI_BASE     = 16;
  localparam int CNT_W       = ADDR_W + 1;
  localparam int POP_W       = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_FIXABLE  = 2'd1,
    ST_CODE_BAD = 2'd2,
    ST_UNCORR   = 2'd3
  } ecc_status_t;

  // 3-byte code -> 32-bit word with split nibbles of byte 2
  function automatic logic [WORD_W-1:0] unpack_code(input logic [CODE_W-1:0] c);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[7:0]   = c[7:0];
    w[23:16] = c[15:8];
    w[27:24] = c[23:20];
    w[11:8]  = c[19:16];
    return w;
  endfunction

  function automatic logic [CODE_W-1:0] pack_word(input logic [WORD_W-1:0] w);
    return {w[27:24], w[11:8], w[23:16], w[7:0]};
  endfunction

  // parity contribution of one byte at a given chunk address
  function automatic logic [WORD_W-1:0] byte_contrib(input logic [7:0] d,
                                                     input logic [ADDR_W-1:0] a);
    logic [WORD_W-1:0] w;
    logic              p;
    w = '0;
    for (int b = 0; b < 8; b++) begin
      if (d[b]) begin
        for (int k = 0; k < BIT_W; k++) begin
          if (b[k]) w[HI_BASE+k] = ~w[HI_BASE+k];
          else      w[k]         = ~w[k];
        end
      end
    end
    p = ^d;
    for (int k = 0; k < ADDR_W; k++) begin
      if (a[k]) w[HI_BASE+BIT_W+k] = w[HI_BASE+BIT_W+k] ^ p;
      else      w[BIT_W+k]         = w[BIT_W+k] ^ p;
    end
    return w;
  endfunction

  function automatic logic [POP_W-1:0] pop_count(input logic [WORD_W-1:0] w);
    logic [POP_W-1:0] n;
    n = '0;
    for (int i = 0; i < WORD_W; i++) n = n + POP_W'(w[i]);
    return n;
  endfunction
endpackage

// File: rtl/ecc_accum.sv
module ecc_accum
  import nand_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic [WORD_W-1:0] acc_word,
  output logic              done_pulse,
  output logic              complete
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(CHUNK_BYTES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CHUNK_BYTES - 1);

  logic [CNT_W-1:0] count;
  logic             take;
  logic             last_take;

  assign complete  = (count == FULL_CNT);
  assign take      = in_valid && !complete;
  assign last_take = take && (count == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_word   <= '0;
      count      <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= last_take;
      if (take) begin
        acc_word <= acc_word ^ byte_contrib(in_byte, count[ADDR_W-1:0]);
        count    <= count + 1'b1;
      end
    end
  end

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
  // R3
  full_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && !clr) |=> $stable(acc_word));
  // R1
  clr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0) && (acc_word == '0) && !done_pulse);
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import nand_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cmp_go,
  input  logic [CODE_W-1:0] stored_code,
  input  logic [WORD_W-1:0] calc_word,
  output logic              result_valid,
  output ecc_status_t       status,
  output logic [ADDR_W-1:0] err_byte,
  output logic [BIT_W-1:0]  err_bit
);
  localparam logic [WORD_W-1:0] ERASED_WORD = unpack_code({CODE_W{1'b1}});
  localparam logic [POP_W-1:0]  PAIRS_CNT   = POP_W'(PAIRS);
  localparam logic [POP_W-1:0]  ONE_CNT     = POP_W'(1);

  // stage 1: syndrome
  logic [WORD_W-1:0] syn_q;
  logic              erased_q;
  logic              s1_valid;
  logic [WORD_W-1:0] stored_word;

  assign stored_word = unpack_code(stored_code);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      syn_q    <= '0;
      erased_q <= 1'b0;
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= cmp_go;
      if (cmp_go) begin
        syn_q    <= stored_word ^ calc_word;
        erased_q <= (stored_word == ERASED_WORD) && (calc_word == '0);
      end
    end
  end

  // stage 2: weight and classification
  logic [POP_W-1:0] weight;
  ecc_status_t      cls;
  assign weight = pop_count(syn_q);

  always_comb begin
    if (syn_q == '0 || erased_q) cls = ST_CLEAN;
    else if (weight == PAIRS_CNT) cls = ST_FIXABLE;
    else if (weight == ONE_CNT)   cls = ST_CODE_BAD;
    else                          cls = ST_UNCORR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      result_valid <= 1'b0;
      status       <= ST_CLEAN;
      err_byte     <= '0;
      err_bit      <= '0;
    end else if (s1_valid) begin
      result_valid <= 1'b1;
      status       <= cls;
      err_byte     <= (cls == ST_FIXABLE) ? syn_q[HI_BASE+BIT_W +: ADDR_W] : '0;
      err_bit      <= (cls == ST_FIXABLE) ? syn_q[HI_BASE +: BIT_W] : '0;
    end
  end

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_go && !clr ##1 !clr) |=> result_valid);
  // R10
  idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status != ST_FIXABLE) |-> (err_byte == '0) && (err_bit == '0));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !s1_valid && !clr) |=> $stable(status) && result_valid);
  // R1
  clr_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !result_valid && (status == ST_CLEAN));
endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine
  import nand_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              cmp_req,
  input  logic [CODE_W-1:0] stored_code,
  output logic [CODE_W-1:0] code_out,
  output logic              code_done,
  output logic              result_valid,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] err_byte,
  output logic [BIT_W-1:0]  err_bit
);
  logic [WORD_W-1:0] acc_word;
  logic              complete;
  logic              cmp_go;
  ecc_status_t       status_e;

  ecc_accum u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .acc_word   (acc_word),
    .done_pulse (code_done),
    .complete   (complete)
  );

  assign cmp_go = cmp_req && complete && !clr;

  ecc_classify u_classify (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr),
    .cmp_go       (cmp_go),
    .stored_code  (stored_code),
    .calc_word    (acc_word),
    .result_valid (result_valid),
    .status       (status_e),
    .err_byte     (err_byte),
    .err_bit      (err_bit)
  );

  assign code_out = pack_word(acc_word);
  assign status   = status_e;

  // R3
  done_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_done |-> complete);
  // R10
  early_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr ##1 !complete) |-> !cmp_go);
endmodule

// File: tb/tb_nand_ecc_engine.sv
module tb_nand_ecc_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        cmp_req = 1'b0;
  logic [23:0] stored_code = '0;
  logic [23:0] code_out;
  logic        code_done;
  logic        result_valid;
  logic [1:0]  status;
  logic [8:0]  err_byte;
  logic [2:0]  err_bit;

  nand_ecc_engine dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_byte(in_byte),
    .cmp_req(cmp_req), .stored_code(stored_code), .code_out(code_out),
    .code_done(code_done), .result_valid(result_valid), .status(status),
    .err_byte(err_byte), .err_bit(err_bit)
  );

  always #5 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] mem [512];

  task automatic chk(input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // reference code: integer arithmetic over the 4096 bit positions
  function automatic int ref_code();
    int t = 0, c = 0, u;
    for (int pos = 0; pos < 4096; pos++) begin
      if (mem[pos / 8][pos % 8]) begin
        for (int k = 0; k < 12; k++) begin
          if (((pos >> k) & 1) == 1) t = t ^ (1 << k);
          else                       c = c ^ (1 << k);
        end
      end
    end
    u = (t << 16) | c;
    return (u & 255) | (((u >> 16) & 255) << 8) |
           ((((u >> 24) & 15) * 16 + ((u >> 8) & 15)) << 16);
  endfunction

  function automatic int widen(input int c);
    return (c & 255) + (((c >> 8) & 255) * 65536) +
           (((c >> 20) & 15) * 16777216) + (((c >> 16) & 15) * 256);
  endfunction

  task automatic ref_class(input int s, input int calc, output int st,
                           output int eb, output int ebit);
    int syn, w;
    syn = widen(s) ^ widen(calc);
    w = 0;
    for (int i = 0; i < 32; i++) w += (syn >> i) & 1;
    eb = 0; ebit = 0;
    if (syn == 0 || (widen(s) == 32'h0FFF0FFF && calc == 0)) st = 0;
    else if (w == 12) begin st = 1; ebit = (syn >> 16) & 7; eb = (syn >> 19) & 511; end
    else if (w == 1) st = 2;
    else st = 3;
  endtask

  task automatic start();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R1 result_valid after clr", result_valid, 0);
    chk("R1 status after clr", status, 0);
    chk("R1 code_done after clr", code_done, 0);
  endtask

  task automatic feed(input bit gaps);
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      chk("R3 no early code_done", code_done, 0);
      if (gaps && (i % 61) == 7) begin
        in_valid = 1'b0;
        @(negedge clk);
        chk("R3 no early code_done", code_done, 0);
      end
      in_valid = 1'b1;
      in_byte  = mem[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3 code_done pulse", code_done, 1);
    @(negedge clk);
    chk("R3 code_done single", code_done, 0);
  endtask

  task automatic compare(input int s, input bit fresh, input string tag,
                         input int es, input int eb, input int ebit);
    @(negedge clk); cmp_req = 1'b1; stored_code = s[23:0];
    @(negedge clk); cmp_req = 1'b0;
    if (fresh) chk("R10 not valid after one edge", result_valid, 0);
    @(negedge clk);
    chk({tag, " result_valid"}, result_valid, 1);
    chk({tag, " status"}, status, es);
    chk({tag, " err_byte"}, err_byte, eb);
    chk({tag, " err_bit"}, err_bit, ebit);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int good, calc, st, eb, ebit;
    int bytes [4] = '{0, 511, 300, 77};
    int bits  [4] = '{0, 7, 5, 2};

    repeat (3) @(negedge clk);
    chk("R1 code_done in reset", code_done, 0);
    chk("R1 result_valid in reset", result_valid, 0);
    chk("R1 status in reset", status, 0);
    chk("R1 err_byte in reset", err_byte, 0);
    rst_n = 1'b1;

    // random chunk
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
    good = ref_code();
    start();
    @(negedge clk); cmp_req = 1'b1; stored_code = good[23:0];
    @(negedge clk); cmp_req = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 early compare ignored", result_valid, 0);
    feed(1'b1);
    chk("R2 code_out", code_out, good);
    compare(good, 1'b1, "R5 match", 0, 0, 0);
    ref_class(good ^ (1 << 13), good, st, eb, ebit);
    chk("R7 model agrees", st, 2);
    compare(good ^ (1 << 13), 1'b0, "R7 stored bit flip", 2, 0, 0);
    repeat (3) @(negedge clk);
    chk("R10 status held", status, 2);
    chk("R10 valid held", result_valid, 1);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk); in_valid = 1'b1; in_byte = 8'($urandom);
      chk("R3 no done on extra bytes", code_done, 0);
    end
    @(negedge clk); in_valid = 1'b0;
    chk("R3 extra bytes ignored", code_out, good);
    compare(good, 1'b0, "R5 rematch", 0, 0, 0);

    // single data-bit errors
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 2));
      good = ref_code();
      mem[bytes[p]][bits[p]] = ~mem[bytes[p]][bits[p]];
      calc = ref_code();
      start();
      feed(1'b0);
      chk("R2 code_out flipped", code_out, calc);
      ref_class(good, calc, st, eb, ebit);
      chk("R6 model byte", eb, bytes[p]);
      compare(good, 1'b1, "R6 single bit", 1, bytes[p], bits[p]);
    end

    // double data-bit error
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
    good = ref_code();
    mem[10][3] = ~mem[10][3];
    mem[10][4] = ~mem[10][4];
    calc = ref_code();
    ref_class(good, calc, st, eb, ebit);
    start();
    feed(1'b1);
    compare(good, 1'b1, "R9 double bit", st, 0, 0);
    chk("R9 model uncorrectable", st, 3);

    // erased chunk
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    start();
    feed(1'b0);
    chk("R4 erased code zero", code_out, 0);
    compare(24'hFFFFFF, 1'b1, "R8 erased page", 0, 0, 0);
    ref_class(24'hFFFFFE, 0, st, eb, ebit);
    compare(24'hFFFFFE, 1'b0, "R9 near-erased", st, 0, 0);
    chk("R9 near-erased model", st, 3);

    start();
    chk("R1 err_byte after clr", err_byte, 0);
    finish_run();
  end
endmodule